// File: doc/BRIEF.md
# Shared Timer Prescaler with Synchronized Halt

This block feeds two timer/counters from one free-running 10-bit divider. For each timer, a 3-bit clock-select input picks the count-enable source. The choices are: off, every system clock, one of four divided rates, or an external clock pin on its falling or rising edge. The external pin passes through a two-flop synchronizer and a registered edge detector, and it never goes through the divider. Each output is a count-enable pulse one system clock wide. The timer that consumes it advances on every cycle in which the pulse is high.

An 8-bit control register holds the prescaler reset. A sync-mode bit makes that reset sticky. Software sets sync mode together with the reset bit, and both timers then stay frozen while it loads them. A later write with sync mode cleared drops the reset, and both timers restart on the same clock edge. With sync mode off, a reset write clears the divider for a single cycle only. The register also holds a capture-source select bit, which goes straight to an output for use by logic outside the block.

Top module: `timer_prescaler_sync`

## Requirements
- R1: Control register layout: bit 7 is sync mode, bit 6 is capture select, bit 0 is prescaler reset, and bits 5..1 always read 0. Every bit reads 0 after reset, and bit 6 also drives `cap_sel`.
- R2: A write with bit 7 = 1 and bit 0 = 1 makes bit 0 read 1. While bit 0 reads 1, both count-enable outputs stay 0 for every clock-select value.
- R3: Any write with bit 7 = 0 makes bit 0 read 0 from the next cycle. The divider restarts from 0. In the first cycle after the write edge, a select of 1 gives a pulse, and a divide-by-N select first pulses N-1 cycles after that.
- R4: A write with bit 7 = 0 and bit 0 = 1 suppresses both outputs for exactly one cycle, and bit 0 still reads 0. The divider restarts, so the first divide-by-8 pulse comes 8 cycles after that suppressed cycle.
- R5: Clock-select encoding is 0 = stopped, 1 = every cycle, 2 = divide by 8, 3 = divide by 64, 4 = divide by 256, 5 = divide by 1024. Over 2048 cycles from a release, the counts are 2048/N single-cycle pulses.
- R6: Select 7 counts rising edges of the timer's external pin and select 6 counts falling edges. A pin change made between clock edges gives one pulse in the cycle after the third rising clock edge. The pulse is not prescaled and the opposite edge gives none. Each edge is counted when the pin half-period is at least two clocks.
- R7: An external edge whose pulse would fall in a halted cycle is dropped. One whose pulse falls in the first cycle after a release is delivered in that same cycle.
- R8: The two timers' selects are independent. Each output follows only its own select and its own pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_wr_data | input | 8 | Control register write value |
| ctl_rd_data | output | 8 | Control register read value |
| cap_sel | output | 1 | Capture-source select bit |
| tmr_a_sel | input | 3 | Clock select for timer A |
| tmr_b_sel | input | 3 | Clock select for timer B |
| tmr_a_ext | input | 1 | External clock pin for timer A |
| tmr_b_ext | input | 1 | External clock pin for timer B |
| tmr_a_tick | output | 1 | Count enable for timer A |
| tmr_b_tick | output | 1 | Count enable for timer B |

## Verification
The release of a sticky halt can land in the same cycle as an external-edge pulse that left the synchronizer earlier. The bench provokes this by raising timer A's pin three cycles ahead of the release write, while timer B runs undivided. The check expects both enables high in the first free cycle. The same pin edge moved one cycle earlier, so that its pulse falls in the last halted cycle, must produce no enable at all.

// File: rtl/tps_pkg.sv
// Package: shared constants, clock-select encoding and divider tap widths
// for the shared timer prescaler. Assumes a divider of at least 10 bits.
package tps_pkg;

    localparam int REG_W     = 8;
    localparam int SYNC_BIT  = 7;
    localparam int CAP_BIT   = 6;
    localparam int RST_BIT   = 0;
    localparam int CSEL_W    = 3;
    localparam int NUM_TAPS  = 4;
    localparam int NUM_TMR   = 2;

    typedef enum logic [CSEL_W-1:0] {
        CS_STOP     = 3'd0,
        CS_DIV1     = 3'd1,
        CS_DIV8     = 3'd2,
        CS_DIV64    = 3'd3,
        CS_DIV256   = 3'd4,
        CS_DIV1024  = 3'd5,
        CS_EXT_FALL = 3'd6,
        CS_EXT_RISE = 3'd7
    } csel_e;

    // Number of low divider bits that must all be one for a tap's terminal count.
    function automatic int tap_width(input int idx);
        case (idx)
            0:       return 3;
            1:       return 6;
            2:       return 8;
            default: return 10;
        endcase
    endfunction

endpackage

// File: rtl/tps_ctrl_reg.sv
// Control register: sync mode, capture select and prescaler reset.
// With sync mode set, the reset bit is held as written. A write with sync
// mode clear drops the held reset, and a reset bit written alongside it
// becomes a one-cycle pulse that never reads back as 1.
module tps_ctrl_reg
    import tps_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             cap_sel,
    output logic             hold
);

    logic sync_q;
    logic cap_q;
    logic rst_hold_q;
    logic rst_pulse_q;
    logic unused_wr_bits;

    assign unused_wr_bits = ^wr_data;

    // Register update: sticky reset in sync mode, single pulse otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q      <= 1'b0;
            cap_q       <= 1'b0;
            rst_hold_q  <= 1'b0;
            rst_pulse_q <= 1'b0;
        end else if (wr_en) begin
            sync_q      <= wr_data[SYNC_BIT];
            cap_q       <= wr_data[CAP_BIT];
            rst_hold_q  <= wr_data[SYNC_BIT] & wr_data[RST_BIT];
            rst_pulse_q <= ~wr_data[SYNC_BIT] & wr_data[RST_BIT];
        end else begin
            rst_pulse_q <= 1'b0;
        end
    end

    // Read value: defined bits in place, everything else reads zero.
    always_comb begin
        rd_data           = '0;
        rd_data[SYNC_BIT] = sync_q;
        rd_data[CAP_BIT]  = cap_q;
        rd_data[RST_BIT]  = rst_hold_q;
    end

    assign cap_sel = cap_q;
    assign hold    = rst_hold_q | rst_pulse_q;

endmodule

// File: rtl/tps_divider.sv
// Shared free-running divider. Held at zero while hold is high. Each tap
// pulses for one cycle when its low bits are all ones. Assumes DIV_W >= 10.
module tps_divider
    import tps_pkg::*;
#(
    parameter int DIV_W = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hold,
    output logic [NUM_TAPS-1:0] tick
);

    logic [DIV_W-1:0] cnt_q;

    // Counter: clear on reset or hold, otherwise increment and wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

    // Terminal-count taps, one per divided rate.
    generate
        for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
            localparam int TW = tap_width(i);
            assign tick[i] = !hold && (&cnt_q[TW-1:0]);
        end
    endgenerate

endmodule

// File: rtl/tps_ext_edge.sv
// External clock path: STAGES flip-flops of synchronizer, then a registered
// edge detector. A pin change between clock edges shows up as a one-cycle
// pulse after the third rising clock edge (for STAGES = 2). Assumes
// STAGES >= 2 and a pin half-period longer than one system clock.
module tps_ext_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise_q,
    output logic fall_q
);

    logic [STAGES-1:0] sync_q;
    logic              last_q;

    // Synchronizer shift, previous-level store and edge pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
            rise_q <= 1'b0;
            fall_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin};
            last_q <= sync_q[STAGES-1];
            rise_q <= sync_q[STAGES-1] & ~last_q;
            fall_q <= ~sync_q[STAGES-1] & last_q;
        end
    end

endmodule

// File: rtl/tps_clk_sel.sv
// Per-timer source select: maps a clock-select code onto a divider tap, a
// constant or an external edge. Every source is gated by the prescaler hold.
module tps_clk_sel
    import tps_pkg::*;
(
    input  logic [CSEL_W-1:0]   sel,
    input  logic                hold,
    input  logic [NUM_TAPS-1:0] tick,
    input  logic                rise,
    input  logic                fall,
    output logic                en
);

    logic en_raw;

    // Source decode per clock-select code.
    always_comb begin
        case (csel_e'(sel))
            CS_STOP:     en_raw = 1'b0;
            CS_DIV1:     en_raw = 1'b1;
            CS_DIV8:     en_raw = tick[0];
            CS_DIV64:    en_raw = tick[1];
            CS_DIV256:   en_raw = tick[2];
            CS_DIV1024:  en_raw = tick[3];
            CS_EXT_FALL: en_raw = fall;
            CS_EXT_RISE: en_raw = rise;
            default:     en_raw = 1'b0;
        endcase
    end

    assign en = en_raw & ~hold;

endmodule

// File: rtl/timer_prescaler_sync.sv
// Top: control register, one shared divider and one external-edge path plus
// source select per timer. Inputs are assumed synchronous to clk, except
// the external pins, which go through the synchronizer.
module timer_prescaler_sync
    import tps_pkg::*;
#(
    parameter int DIV_W       = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr_en,
    input  logic [REG_W-1:0]  ctl_wr_data,
    output logic [REG_W-1:0]  ctl_rd_data,
    output logic              cap_sel,
    input  logic [CSEL_W-1:0] tmr_a_sel,
    input  logic [CSEL_W-1:0] tmr_b_sel,
    input  logic              tmr_a_ext,
    input  logic              tmr_b_ext,
    output logic              tmr_a_tick,
    output logic              tmr_b_tick
);

    logic                hold;
    logic [NUM_TAPS-1:0] tick;
    logic [NUM_TMR-1:0]  ext_pin;
    logic [CSEL_W-1:0]   sel   [NUM_TMR];
    logic [NUM_TMR-1:0]  rise;
    logic [NUM_TMR-1:0]  fall;
    logic [NUM_TMR-1:0]  en;

    assign ext_pin = {tmr_b_ext, tmr_a_ext};
    assign sel[0]  = tmr_a_sel;
    assign sel[1]  = tmr_b_sel;

    tps_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ctl_wr_en),
        .wr_data (ctl_wr_data),
        .rd_data (ctl_rd_data),
        .cap_sel (cap_sel),
        .hold    (hold)
    );

    tps_divider #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (hold),
        .tick  (tick)
    );

    generate
        for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
            tps_ext_edge #(.STAGES(SYNC_STAGES)) u_edge (
                .clk    (clk),
                .rst_n  (rst_n),
                .pin    (ext_pin[t]),
                .rise_q (rise[t]),
                .fall_q (fall[t])
            );

            tps_clk_sel u_sel (
                .sel  (sel[t]),
                .hold (hold),
                .tick (tick),
                .rise (rise[t]),
                .fall (fall[t]),
                .en   (en[t])
            );
        end
    endgenerate

    assign tmr_a_tick = en[0];
    assign tmr_b_tick = en[1];

endmodule

// File: rtl/tps_checker.sv
// Checker: port-level properties of the shared prescaler, bound to the top.
module tps_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       ctl_wr_en,
    input logic [7:0] ctl_wr_data,
    input logic [7:0] ctl_rd_data,
    input logic       cap_sel,
    input logic [2:0] tmr_a_sel,
    input logic [2:0] tmr_b_sel,
    input logic       tmr_a_tick,
    input logic       tmr_b_tick
);

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rd_data[5:1] == 5'd0); // R1

    AST_CAP_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr_en |=> (cap_sel == $past(ctl_wr_data[6]))); // R1

    AST_HALT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rd_data[0] |-> (!tmr_a_tick && !tmr_b_tick)); // R2

    AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr_en && !ctl_wr_data[7]) |=> !ctl_rd_data[0]); // R3

    AST_PULSE_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr_en && !ctl_wr_data[7] && ctl_wr_data[0]) |=> (!tmr_a_tick && !tmr_b_tick)); // R4

    AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_a_sel == 3'd0) |-> !tmr_a_tick); // R5

    AST_EXT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_a_sel[2:1] == 2'b11 && tmr_a_tick) |=> (!$stable(tmr_a_sel) || !tmr_a_tick)); // R6

    AST_B_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_b_sel == 3'd0) |-> !tmr_b_tick); // R8

endmodule

bind timer_prescaler_sync tps_checker u_tps_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_wr_en   (ctl_wr_en),
    .ctl_wr_data (ctl_wr_data),
    .ctl_rd_data (ctl_rd_data),
    .cap_sel     (cap_sel),
    .tmr_a_sel   (tmr_a_sel),
    .tmr_b_sel   (tmr_b_sel),
    .tmr_a_tick  (tmr_a_tick),
    .tmr_b_tick  (tmr_b_tick)
);

// File: tb/test_timer_prescaler_sync.sv
// Bench: a vector table of select pairs walked after each release, then
// directed tests for the register, the single-cycle reset, external edges
// and a release that coincides with an external pulse.
module test_timer_prescaler_sync;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       cap_sel;
    logic [2:0] sel_a = 3'd0;
    logic [2:0] sel_b = 3'd0;
    logic       ext_a = 1'b0;
    logic       ext_b = 1'b0;
    logic       tick_a;
    logic       tick_b;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    // Columns: sel_a, sel_b, first_a, first_b, count_a, count_b over 2048 cycles.
    localparam int NV = 6;
    localparam int VEC [NV][6] = '{
        '{1, 2,    0,    7, 2048, 256},
        '{2, 3,    7,   63,  256,  32},
        '{3, 4,   63,  255,   32,   8},
        '{4, 5,  255, 1023,    8,   2},
        '{5, 0, 1023,   -1,    2,   0},
        '{0, 1,   -1,    0,    0, 2048}
    };

    always #5 clk = ~clk;

    timer_prescaler_sync i_timer_prescaler_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl_wr_en   (wr_en),
        .ctl_wr_data (wr_data),
        .ctl_rd_data (rd_data),
        .cap_sel     (cap_sel),
        .tmr_a_sel   (sel_a),
        .tmr_b_sel   (sel_b),
        .tmr_a_ext   (ext_a),
        .tmr_b_ext   (ext_b),
        .tmr_a_tick  (tick_a),
        .tmr_b_tick  (tick_b)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Write the register; returns at the negedge just after the capturing edge.
    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int first_a, first_b, cnt_a, cnt_b;
        idle(3);
        // Reset state, R1
        chk("R1 reset readback", rd_data, 0);
        chk("R1 reset cap_sel", cap_sel, 0);
        chk("R5 stop during reset state", tick_a, 0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        // Vector table: R2 halt, R3 release, R5 rates, R8 independence
        for (int v = 0; v < NV; v++) begin
            wr(8'h81);
            sel_a = VEC[v][0];
            sel_b = VEC[v][1];
            @(negedge clk);
            chk("R2 held bit reads 1", rd_data[0], 1);
            chk("R2 halted A", tick_a, 0);
            chk("R2 halted B", tick_b, 0);
            wr(8'h00);
            chk("R3 release clears bit 0", rd_data[0], 0);
            first_a = -1; first_b = -1; cnt_a = 0; cnt_b = 0;
            for (int k = 0; k < 2048; k++) begin
                if (tick_a) begin if (first_a < 0) first_a = k; cnt_a++; end
                if (tick_b) begin if (first_b < 0) first_b = k; cnt_b++; end
                @(negedge clk);
            end
            chk("R3 first pulse A", first_a, VEC[v][2]);
            chk("R3 first pulse B", first_b, VEC[v][3]);
            chk("R5 pulse count A", cnt_a, VEC[v][4]);
            chk("R8 pulse count B", cnt_b, VEC[v][5]);
        end

        // Register layout, R1
        wr(8'hFF);
        chk("R1 reserved bits read zero", rd_data, 8'hC1);
        chk("R1 cap_sel follows bit 6", cap_sel, 1);
        wr(8'h40);
        chk("R3 clearing sync clears reset bit", rd_data, 8'h40);
        wr(8'h3E);
        chk("R1 reserved bits not stored", rd_data, 8'h00);
        chk("R1 cap_sel cleared", cap_sel, 0);

        // Single-cycle reset, R4
        sel_a = 3'd1; sel_b = 3'd2;
        idle(20);
        wr(8'h01);
        chk("R4 bit 0 reads 0", rd_data[0], 0);
        chk("R4 suppressed A", tick_a, 0);
        chk("R4 suppressed B", tick_b, 0);
        cnt_b = 0;
        for (int j = 0; j < 8; j++) begin
            @(negedge clk);
            chk("R4 A resumes", tick_a, 1);
            if (j < 7) cnt_b += tick_b;
            else chk("R4 first div8 after restart", tick_b, 1);
        end
        chk("R4 no early div8", cnt_b, 0);

        // External edges, R6
        sel_a = 3'd7; sel_b = 3'd0; ext_a = 1'b0;
        idle(5);
        ext_a = 1'b1;
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            chk("R6 rising edge latency", tick_a, (k == 3) ? 1 : 0);
        end
        sel_a = 3'd6;
        idle(2);
        ext_a = 1'b0;
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            chk("R6 falling edge latency", tick_a, (k == 3) ? 1 : 0);
        end
        cnt_a = 0;
        ext_a = 1'b1;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            cnt_a += tick_a;
        end
        chk("R6 rising ignored on falling select", cnt_a, 0);
        sel_a = 3'd7;
        ext_a = 1'b0;
        idle(5);
        cnt_a = 0;
        for (int k = 0; k < 40; k++) begin
            if (k % 2 == 0) ext_a = ~ext_a;
            @(negedge clk);
            cnt_a += tick_a;
        end
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            cnt_a += tick_a;
        end
        chk("R6 one pulse per rising edge, not prescaled", cnt_a, 10);

        // Release coinciding with an external pulse, R7
        ext_a = 1'b0; sel_b = 3'd1;
        wr(8'h81);
        idle(5);
        ext_a = 1'b1;
        @(negedge clk);
        @(negedge clk);
        wr_en = 1'b1; wr_data = 8'h00;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R7 edge delivered on release cycle A", tick_a, 1);
        chk("R7 release cycle B", tick_b, 1);
        ext_a = 1'b0;
        idle(5);
        wr(8'h81);
        idle(5);
        ext_a = 1'b1;
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        chk("R7 edge during halt dropped", tick_a, 0);
        wr_en = 1'b1; wr_data = 8'h00;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R7 no late pulse after release", tick_a, 0);
        chk("R7 B resumes", tick_b, 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule